// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a clocked static memory meant to hold the data lines of a processor's secondary cache. Each access starts on a rising clock edge. Two start strobes can open an access. One comes from the processor and always reads. The other comes from the cache controller and reads or writes, depending on the write-enable input. After that first beat, a burst-step input moves through the other three words of a four-word line in processor interleaved order. A cycle with the step input held high repeats the current word, which is how the cache controller inserts wait states. Writes complete inside the clock cycle that samples them. Read data is registered and leaves the block through a drive-enable output, which an output-enable input gates without reference to the clock.

Control lives in a two-state machine. `ST_IDLE` means no burst is selected. `ST_BURST` means a selected burst is open. The machine has three transitions. *open* happens on any start edge where the chip-select pair is true and leads to `ST_BURST`. *close* happens on any start edge where the pair is false and leads to `ST_IDLE`. *hold* happens on every edge without a start strobe and keeps the current state. The cache configuration instantiates the block with `ADDR_W = 15`, which gives 32,768 nine-bit words. The default of 10 keeps elaboration small.

Top module: `burst_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits. A write to any address, including the lowest and the highest, is returned unchanged by a later read of that address.
- R2: When `proc_start_n` is low on an edge, the block loads `addr` as the burst base. The access on that edge is a read of `addr`, whatever the values of `wr_n` and `ctl_start_n`.
- R3: When `ctl_start_n` is low and `proc_start_n` is high on an edge, the block loads `addr` as the base. It writes `din` to `addr` if `wr_n` is low, and reads `addr` if `wr_n` is high.
- R4: The block samples `cs_hi` and `cs_lo_n` only on edges that have a start strobe. It is selected when `cs_lo_n`=0 and `cs_hi`=1. A start edge with any other pair does no access. Every later edge without a strobe then neither writes the array nor returns data until a selected start edge.
- R5: On an edge without a strobe inside a selected burst, `step_n`=0 advances the beat count before the access. `step_n`=1 accesses the same word again, which is a wait state.
- R6: The address of the burst word is the base's upper ADDR_W-2 bits followed by the base's low two bits XOR the 2-bit beat count. The count starts at 0 on a load and wraps after four steps. For a base whose low bits are 2, the order is 2,3,0,1 and then 2 again.
- R7: `dq_valid` is 1 during the cycle after an edge that performed a read, and carries that read's word. It is 0 after a write, after an edge with no access, and after reset.
- R8: `dq_drive` equals `dq_valid` AND NOT `oe_n`, and follows `oe_n` without waiting for a clock edge. `dq_out` is all zeros whenever `dq_drive` is 0.
- R9: On a burst opened by `proc_start_n`, `wr_n` is ignored on the first beat. Later edges without a strobe write `din` when `wr_n` is low.
- R10: Synchronous active-low reset puts the block in `ST_IDLE` with `dq_valid` and `dq_drive` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | External word address |
| din | input | DATA_W | Write data |
| wr_n | input | 1 | Write enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| proc_start_n | input | 1 | Processor start strobe, always a read |
| ctl_start_n | input | 1 | Controller start strobe, read or write |
| step_n | input | 1 | Burst step, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | DATA_W | Read data, zero while not driven |
| dq_drive | output | 1 | Output driver enable |
| dq_valid | output | 1 | Registered read-data valid |

## Verification
The assertions assume that every input is a settled 0 or 1 at each rising edge. They also assume that `oe_n` changes only at points where the drive output is sampled combinationally. The counter properties assume that both strobes stay high on each edge they cover. To keep within this, the bench drives every input half a period away from the edge. It changes `oe_n` mid-cycle only while the strobes keep the burst state still. Each cycle is compared against a behavioural model that holds the array, base, beat count and selection.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_BURST} bstate_e;
    typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic proc_start_n,
    input  logic ctl_start_n,
    input  logic step_n,
    input  logic wr_n,
    input  logic cs_hi,
    input  logic cs_lo_n,
    output logic load,
    output logic advance,
    output op_e  op
);
    bstate_e state_q, state_d;
    logic    sel_now;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        sel_now = cs_hi && !cs_lo_n;
        load    = !proc_start_n || !ctl_start_n;
        advance = 1'b0;
        state_d = state_q;
        op      = OP_NONE;
        if (!proc_start_n) begin
            // open/close; first beat always reads
            state_d = sel_now ? ST_BURST : ST_IDLE;
            op      = sel_now ? OP_READ : OP_NONE;
        end else if (!ctl_start_n) begin
            state_d = sel_now ? ST_BURST : ST_IDLE;
            if (sel_now) op = wr_n ? OP_READ : OP_WRITE;
        end else begin
            // hold
            unique case (state_q)
                ST_IDLE: begin
                    op = OP_NONE;
                end
                ST_BURST: begin
                    advance = !step_n;
                    op      = wr_n ? OP_READ : OP_WRITE;
                end
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/burst_addr.sv
`timescale 1ns/1ps
module burst_addr #(
    parameter int ADDR_W = 10,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] cnt_use;

    always_comb begin
        cnt_use  = advance ? cnt_q + BEAT_W'(1) : cnt_q;
        eff_addr = load ? ext_addr
                        : {base_q[ADDR_W-1:BEAT_W], base_q[BEAT_W-1:0] ^ cnt_use};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q  <= cnt_use;
        end
    end
endmodule

// File: rtl/burst_array.sv
`timescale 1ns/1ps
module burst_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op == OP_WRITE) mem[addr] <= wdata;
        if (op == OP_READ)  rdata     <= mem[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= (op == OP_READ);
    end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              proc_start_n,
    input  logic              ctl_start_n,
    input  logic              step_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              dq_valid
);
    logic              load;
    logic              advance;
    op_e               op;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] rdata;

    burst_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .proc_start_n(proc_start_n), .ctl_start_n(ctl_start_n),
        .step_n(step_n), .wr_n(wr_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .load(load), .advance(advance), .op(op)
    );

    burst_addr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .ext_addr(addr), .eff_addr(eff_addr)
    );

    burst_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(eff_addr),
        .wdata(din), .rdata(rdata), .rvalid(dq_valid)
    );

    assign dq_drive = dq_valid && !oe_n;

    for (genvar b = 0; b < DATA_W; b++) begin : g_gate
        assign dq_out[b] = dq_drive & rdata[b];
    end
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_start_n,
    input logic              ctl_start_n,
    input logic              step_n,
    input logic              wr_n,
    input logic              cs_hi,
    input logic              cs_lo_n,
    input logic              oe_n,
    input op_e               op,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              dq_valid,
    input logic              dq_drive
);
    logic sel, nostrobe, start;
    assign sel      = cs_hi && !cs_lo_n;
    assign nostrobe = proc_start_n && ctl_start_n;
    assign start    = !proc_start_n || !ctl_start_n;

    assert_proc_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n && sel) |=> dq_valid);

    assert_proc_ignores_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n && sel && !wr_n) |=> dq_valid);

    assert_ctl_write_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_n && !ctl_start_n && !wr_n) |=> !dq_valid);

    assert_deselect_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !sel) |=> !dq_valid);

    assert_deselect_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !sel) ##1 nostrobe |-> (op == OP_NONE));

    assert_drive_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> (dq_valid && !oe_n));

    assert_wait_holds_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nostrobe && op != OP_NONE) ##1 (nostrobe && step_n) |-> $stable(eff_addr));

    assert_step_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nostrobe && op != OP_NONE) ##1 (nostrobe && !step_n)
        |-> ($stable(eff_addr[ADDR_W-1:BEAT_W]) && !$stable(eff_addr[BEAT_W-1:0])));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .proc_start_n(proc_start_n), .ctl_start_n(ctl_start_n),
    .step_n(step_n), .wr_n(wr_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .oe_n(oe_n),
    .op(op), .eff_addr(eff_addr), .dq_valid(dq_valid), .dq_drive(dq_drive)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;
    localparam int AW    = 10;
    localparam int DW    = 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          wr_n = 1'b1, cs_hi = 1'b1, cs_lo_n = 1'b0;
    logic          proc_start_n = 1'b1, ctl_start_n = 1'b1, step_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_drive, dq_valid;

    int  nvec = 0, nerr = 0;
    bit  done = 0;

    // behavioural model
    logic [DW-1:0] mm [int];
    int  m_base = 0, m_cnt = 0;
    bit  m_act = 0;
    bit  ev = 0;
    logic [DW-1:0] ed = '0;

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr_n(wr_n),
        .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .proc_start_n(proc_start_n),
        .ctl_start_n(ctl_start_n), .step_n(step_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_drive(dq_drive), .dq_valid(dq_valid)
    );

    function automatic logic [DW-1:0] pat(int i);
        return DW'((i * 37 + 5) & 9'h1ff);
    endfunction

    task automatic compare(string tag);
        logic          xd;
        logic [DW-1:0] xo;
        xd = ev && !oe_n;
        xo = xd ? ed : '0;
        nvec++;
        if (dq_valid !== ev || dq_drive !== xd || dq_out !== xo) begin
            nerr++;
            $display("FAIL %s: valid/drive/out = %b/%b/%h, expected %b/%b/%h",
                     tag, dq_valid, dq_drive, dq_out, ev, xd, xo);
        end
    endtask

    // one clock: drive at negedge, advance model, compare after the edge
    task automatic cyc(string tag, bit p_n, bit c_n, bit s_n, bit w_n,
                       bit chi, bit clo_n, int a, logic [DW-1:0] d);
        bit sel;
        int ea;
        @(negedge clk);
        proc_start_n = p_n; ctl_start_n = c_n; step_n = s_n; wr_n = w_n;
        cs_hi = chi; cs_lo_n = clo_n; addr = AW'(a); din = d;
        sel = chi && !clo_n;
        ev = 0;
        if (!p_n) begin
            m_base = a; m_cnt = 0; m_act = sel;
            if (sel) begin ev = 1; ed = mm[a]; end
        end else if (!c_n) begin
            m_base = a; m_cnt = 0; m_act = sel;
            if (sel && !w_n) mm[a] = d;
            else if (sel) begin ev = 1; ed = mm[a]; end
        end else if (m_act) begin
            if (!s_n) m_cnt = (m_cnt + 1) % 4;
            ea = (m_base & ~3) | ((m_base & 3) ^ m_cnt);
            if (!w_n) mm[ea] = d;
            else begin ev = 1; ed = mm[ea]; end
        end
        @(posedge clk);
        #2;
        compare(tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        ev = 0;
        compare("R10");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: fill every word through the controller strobe
        for (int i = 0; i < DEPTH; i++) cyc("R1", 1, 0, 1, 0, 1, 0, i, pat(i));
        cyc("R1", 1, 0, 1, 1, 1, 0, 0, '0);
        cyc("R1", 1, 0, 1, 1, 1, 0, DEPTH - 1, '0);

        // R2 / R7: processor strobe reads despite wr_n=0 and ctl_start_n=0
        cyc("R2", 0, 0, 1, 0, 1, 0, 21, 9'h1aa);
        cyc("R7", 1, 1, 1, 1, 1, 0, 0, '0);

        // R6: base low bits 2 -> order 2,3,0,1,2
        cyc("R6", 0, 1, 1, 1, 1, 0, 42, '0);
        for (int k = 0; k < 4; k++) cyc("R6", 1, 1, 0, 1, 1, 0, 0, '0);
        // base low bits 3 -> 3,2,1,0
        cyc("R6", 0, 1, 1, 1, 1, 0, 103, '0);
        for (int k = 0; k < 3; k++) cyc("R6", 1, 1, 0, 1, 1, 0, 0, '0);

        // R5: wait states repeat the word, then step
        cyc("R5", 0, 1, 1, 1, 1, 0, 200, '0);
        cyc("R5", 1, 1, 1, 1, 1, 0, 0, '0);
        cyc("R5", 1, 1, 1, 1, 1, 0, 0, '0);
        cyc("R5", 1, 1, 0, 1, 1, 0, 0, '0);

        // R9: first beat ignores wr_n, later beats write
        cyc("R9", 0, 1, 1, 0, 1, 0, 300, 9'h0f0);
        cyc("R9", 1, 1, 0, 0, 1, 0, 0, 9'h155);
        cyc("R9", 1, 1, 1, 0, 1, 0, 0, 9'h0aa);
        cyc("R9", 0, 1, 1, 1, 1, 0, 300, '0);
        cyc("R9", 1, 1, 0, 1, 1, 0, 0, '0);

        // R3: controller write then read back
        cyc("R3", 1, 0, 1, 0, 1, 0, 512, 9'h13c);
        cyc("R3", 1, 0, 1, 1, 1, 0, 512, '0);

        // R4: deselected start, then continue cycles must not write
        cyc("R4", 1, 0, 1, 1, 0, 0, 600, '0);
        cyc("R4", 1, 1, 0, 0, 1, 0, 0, 9'h1ff);
        cyc("R4", 1, 1, 1, 0, 1, 0, 0, 9'h1ff);
        cyc("R4", 0, 1, 1, 1, 1, 1, 601, '0);
        cyc("R4", 1, 1, 1, 1, 1, 0, 0, '0);
        cyc("R4", 0, 1, 1, 1, 1, 0, 600, '0);
        cyc("R4", 1, 1, 0, 1, 1, 0, 0, '0);

        // R8: output enable gates the drive without a clock edge
        cyc("R8", 0, 1, 1, 1, 1, 0, 700, '0);
        oe_n = 1'b1; #1; compare("R8");
        oe_n = 1'b0; #1; compare("R8");
        oe_n = 1'b1;
        cyc("R8", 1, 1, 1, 1, 1, 0, 0, '0);
        oe_n = 1'b0;
        cyc("R8", 1, 1, 1, 0, 1, 0, 0, 9'h011);

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0)
                cyc("R2", 0, $urandom % 2, 1, $urandom % 2, 1, 0, int'($urandom % DEPTH), '0);
            else if (r == 1)
                cyc("R3", 1, 0, 1, $urandom % 2, ($urandom % 8) != 0, 0,
                    int'($urandom % DEPTH), DW'($urandom));
            else
                cyc("R6", 1, 1, $urandom % 2, ($urandom % 4) != 0, $urandom % 2,
                    $urandom % 2, int'($urandom % DEPTH), DW'($urandom));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule